// File: doc/BRIEF.md
# Privileged Control Register Bank

This block stores the privileged control state of a 32-bit processor whose address translation is refilled by software. A single write port and a combinational read port address the registers by number. On each write, the register's own mask decides which bits change. Hardware interrupt lines and a trap-cause code enter through dedicated inputs, and software cannot overwrite them.

Two results come from the stored state. The first is one interrupt request line. It is formed from the global enable, the per-line mask and the pending bits. The second is a two-bit select that steers data accesses to normal memory, to an isolated cache, or to a swapped cache. Both outputs are combinational functions of the registered state. A write that changes enable, mask or software-pending bits is therefore reflected in the cycle after its clock edge.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to register 10 (translation high) stores only bits 31:6. Bits 5:0 always read as zero.
- R2: A write to register 2 (translation low) stores only bits 31:8. Bits 7:0 always read as zero.
- R3: A write to register 4 (page-table context) changes only bits 31:21. Bits 20:0 keep their prior value, which is zero after reset.
- R4: A write to register 13 (cause) leaves bits 15:10 (hardware pending) and bits 6:2 (cause code) unchanged. Every other bit takes the written data.
- R5: At each clock edge, cause bits 15:10 load from `hw_irq[5:0]`. When `exc_valid` is high, cause bits 6:2 load from `exc_code`.
- R6: `irq_req` is high exactly when status bit 0 (global enable) is set and some bit in cause[15:8] is also set in status[15:8].
- R7: Setting a software pending bit (cause bit 8 or 9) by a write raises `irq_req` in the cycle after that write, if that bit is unmasked and the global enable is set. Clearing the bit by a write drops `irq_req` again.
- R8: `dspace_sel` is 1 when status bits 16 (isolate) and 17 (swap) are both set. It is 2 when only bit 16 is set, and 0 otherwise.
- R9: Register 15 (processor identity) ignores writes and always reads `PRID_VALUE`.
- R10: After reset, every writable register reads zero, `irq_req` is 0 and `dspace_sel` is 0. Unmapped register numbers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register number written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Register number read |
| rd_data | output | 32 | Combinational read data |
| hw_irq | input | 6 | Hardware interrupt lines |
| exc_valid | input | 1 | Load cause code this cycle |
| exc_code | input | 5 | Cause code value |
| irq_req | output | 1 | Combined interrupt request |
| dspace_sel | output | 2 | Data space select |

## Verification
A register write, a hardware line change and a cause-code load each take effect at the first rising edge that samples them. Read data, `irq_req` and `dspace_sel` are due in the same cycle, after that edge, with no further delay. The bench drives every stimulus on a falling edge and leaves one rising edge to pass. It then samples at the following falling edge, or one time unit after moving `rd_addr`. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN       = 32;
    localparam int REG_AW     = 5;
    localparam int HW_IRQ_CNT = 6;
    localparam int SW_IRQ_CNT = 2;
    localparam int IRQ_CNT    = HW_IRQ_CNT + SW_IRQ_CNT;
    localparam int IP_LSB     = 8;
    localparam int HW_LSB     = IP_LSB + SW_IRQ_CNT;
    localparam int CODE_LSB   = 2;
    localparam int CODE_W     = 5;
    localparam int ISO_BIT    = 16;
    localparam int SWP_BIT    = 17;

    localparam logic [REG_AW-1:0] RN_TLO  = 5'd2;
    localparam logic [REG_AW-1:0] RN_CTX  = 5'd4;
    localparam logic [REG_AW-1:0] RN_THI  = 5'd10;
    localparam logic [REG_AW-1:0] RN_STAT = 5'd12;
    localparam logic [REG_AW-1:0] RN_CAUS = 5'd13;
    localparam logic [REG_AW-1:0] RN_PRID = 5'd15;

    localparam logic [XLEN-1:0] THI_WMASK  = 32'hFFFF_FFC0;
    localparam logic [XLEN-1:0] TLO_WMASK  = 32'hFFFF_FF00;
    localparam logic [XLEN-1:0] CTX_WMASK  = 32'hFFE0_0000;
    localparam logic [XLEN-1:0] STAT_WMASK = 32'hFFFF_FFFF;
    localparam logic [XLEN-1:0] CAUS_WMASK =
        ~((((XLEN)'(1) << HW_IRQ_CNT) - 1) << HW_LSB) &
        ~((((XLEN)'(1) << CODE_W) - 1) << CODE_LSB);

    typedef struct packed {
        logic [XLEN-1:0] thi;
        logic [XLEN-1:0] tlo;
        logic [XLEN-1:0] ctx;
        logic [XLEN-1:0] stat;
        logic [XLEN-1:0] caus;
    } ctl_state_t;

    function automatic logic [XLEN-1:0] merge_bits(
        input logic [XLEN-1:0] old_v,
        input logic [XLEN-1:0] new_v,
        input logic [XLEN-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/sysctl_irq_eval.sv
module sysctl_irq_eval
    import sysctl_pkg::*;
(
    input  logic               glb_en,
    input  logic [IRQ_CNT-1:0] pend,
    input  logic [IRQ_CNT-1:0] mask,
    output logic               irq
);
    logic [IRQ_CNT-1:0] hit;

    for (genvar i = 0; i < IRQ_CNT; i++) begin : g_line
        assign hit[i] = pend[i] & mask[i];
    end

    assign irq = glb_en & (|hit);
endmodule

// File: rtl/sysctl_space_dec.sv
module sysctl_space_dec (
    input  logic       iso,
    input  logic       swp,
    output logic [1:0] sel
);
    always_comb begin
        if (!iso)     sel = 2'd0;
        else if (swp) sel = 2'd1;
        else          sel = 2'd2;
    end
endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
    import sysctl_pkg::*;
#(
    parameter logic [XLEN-1:0] PRID_VALUE = 32'h0000_0230
) (
    input  logic [REG_AW-1:0] addr,
    input  ctl_state_t        st,
    output logic [XLEN-1:0]   data
);
    always_comb begin
        unique case (addr)
            RN_TLO:  data = st.tlo;
            RN_CTX:  data = st.ctx;
            RN_THI:  data = st.thi;
            RN_STAT: data = st.stat;
            RN_CAUS: data = st.caus;
            RN_PRID: data = PRID_VALUE;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [XLEN-1:0] PRID_VALUE = 32'h0000_0230
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     wr_addr,
    input  logic [XLEN-1:0]       wr_data,
    input  logic [REG_AW-1:0]     rd_addr,
    output logic [XLEN-1:0]       rd_data,
    input  logic [HW_IRQ_CNT-1:0] hw_irq,
    input  logic                  exc_valid,
    input  logic [CODE_W-1:0]     exc_code,
    output logic                  irq_req,
    output logic [1:0]            dspace_sel
);
    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (wr_addr)
                RN_THI:  state_d.thi  = merge_bits(state_q.thi,  wr_data, THI_WMASK);
                RN_TLO:  state_d.tlo  = merge_bits(state_q.tlo,  wr_data, TLO_WMASK);
                RN_CTX:  state_d.ctx  = merge_bits(state_q.ctx,  wr_data, CTX_WMASK);
                RN_STAT: state_d.stat = merge_bits(state_q.stat, wr_data, STAT_WMASK);
                RN_CAUS: state_d.caus = merge_bits(state_q.caus, wr_data, CAUS_WMASK);
                default: ;
            endcase
        end
        state_d.caus[HW_LSB +: HW_IRQ_CNT] = hw_irq;
        if (exc_valid) begin
            state_d.caus[CODE_LSB +: CODE_W] = exc_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    sysctl_irq_eval u_irq (
        .glb_en (state_q.stat[0]),
        .pend   (state_q.caus[IP_LSB +: IRQ_CNT]),
        .mask   (state_q.stat[IP_LSB +: IRQ_CNT]),
        .irq    (irq_req)
    );

    sysctl_space_dec u_space (
        .iso (state_q.stat[ISO_BIT]),
        .swp (state_q.stat[SWP_BIT]),
        .sel (dspace_sel)
    );

    sysctl_read_mux #(.PRID_VALUE(PRID_VALUE)) u_rd (
        .addr (rd_addr),
        .st   (state_q),
        .data (rd_data)
    );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
#(
    parameter logic [XLEN-1:0] PRID_VALUE = 32'h0000_0230
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_AW-1:0]     wr_addr,
    input logic [XLEN-1:0]       wr_data,
    input logic [REG_AW-1:0]     rd_addr,
    input logic [XLEN-1:0]       rd_data,
    input logic [HW_IRQ_CNT-1:0] hw_irq,
    input logic                  exc_valid,
    input logic [CODE_W-1:0]     exc_code,
    input logic                  irq_req,
    input logic [1:0]            dspace_sel,
    input logic [XLEN-1:0]       thi,
    input logic [XLEN-1:0]       tlo,
    input logic [XLEN-1:0]       ctx,
    input logic [XLEN-1:0]       caus,
    input logic                  st_ie,
    input logic                  st_iso
);
    assert_thi_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RN_THI) |=> thi == ($past(wr_data) & THI_WMASK));

    assert_tlo_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RN_TLO) |=> tlo == ($past(wr_data) & TLO_WMASK));

    assert_ctx_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RN_CTX) |=> ctx[20:0] == $past(ctx[20:0]));

    assert_ctx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == RN_CTX) |=> $stable(ctx));

    assert_cause_code_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RN_CAUS && !exc_valid) |=> caus[6:2] == $past(caus[6:2]));

    assert_cause_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RN_CAUS) |=> caus[31:16] == $past(wr_data[31:16]));

    assert_hw_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> caus[15:10] == $past(hw_irq));

    assert_code_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> caus[6:2] == $past(exc_code));

    assert_irq_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ie |-> !irq_req);

    assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (caus[15:8] == 8'h00) |-> !irq_req);

    assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dspace_sel != 2'd3);

    assert_sel_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_iso |-> dspace_sel == 2'd0);

    assert_prid_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == RN_PRID) |-> rd_data == PRID_VALUE);
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.PRID_VALUE(PRID_VALUE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .hw_irq     (hw_irq),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code),
    .irq_req    (irq_req),
    .dspace_sel (dspace_sel),
    .thi        (state_q.thi),
    .tlo        (state_q.tlo),
    .ctx        (state_q.ctx),
    .caus       (state_q.caus),
    .st_ie      (state_q.stat[0]),
    .st_iso     (state_q.stat[16])
);

// File: tb/sysctl_regfile_test.sv
`timescale 1ns/1ps
module sysctl_regfile_test;
    localparam logic [31:0] PRID = 32'h0000_0230;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [5:0]  hw_irq = '0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        irq_req;
    logic [1:0]  dspace_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysctl_regfile #(.PRID_VALUE(PRID)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_irq(hw_irq), .exc_valid(exc_valid), .exc_code(exc_code),
        .irq_req(irq_req), .dspace_sel(dspace_sel)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        cmp(tag, rd_data, exp);
    endtask

    task automatic t_reset();
        rd_chk("R10 thi", 5'd10, 32'h0);
        rd_chk("R10 tlo", 5'd2, 32'h0);
        rd_chk("R10 ctx", 5'd4, 32'h0);
        rd_chk("R10 stat", 5'd12, 32'h0);
        rd_chk("R10 cause", 5'd13, 32'h0);
        rd_chk("R10 unmapped", 5'd7, 32'h0);
        cmp("R10 irq", {31'd0, irq_req}, 32'd0);
        cmp("R10 sel", {30'd0, dspace_sel}, 32'd0);
    endtask

    task automatic t_masks();
        wr(5'd10, 32'hFFFF_FFFF); rd_chk("R1 ones", 5'd10, 32'hFFFF_FFC0);
        wr(5'd10, 32'h0);         rd_chk("R1 zeros", 5'd10, 32'h0);
        wr(5'd2, 32'hFFFF_FFFF);  rd_chk("R2 ones", 5'd2, 32'hFFFF_FF00);
        wr(5'd2, 32'h0);          rd_chk("R2 zeros", 5'd2, 32'h0);
        wr(5'd4, 32'hFFFF_FFFF);  rd_chk("R3 ones", 5'd4, 32'hFFE0_0000);
        wr(5'd4, 32'h0);          rd_chk("R3 zeros", 5'd4, 32'h0);
        wr(5'd15, 32'hFFFF_FFFF); rd_chk("R9 prid", 5'd15, PRID);
        wr(5'd15, 32'h0);         rd_chk("R9 prid0", 5'd15, PRID);
    endtask

    task automatic t_cause();
        wr(5'd13, 32'hFFFF_FFFF); rd_chk("R4 ones", 5'd13, 32'hFFFF_0383);
        wr(5'd13, 32'h0);         rd_chk("R4 zeros", 5'd13, 32'h0);
        @(negedge clk);
        hw_irq = 6'b101010; exc_valid = 1'b1; exc_code = 5'd9;
        @(negedge clk);
        exc_valid = 1'b0;
        rd_chk("R5 load", 5'd13, 32'h0000_A824);
        wr(5'd13, 32'h0);         rd_chk("R4 keep0", 5'd13, 32'h0000_A824);
        wr(5'd13, 32'hFFFF_FFFF); rd_chk("R4 keep1", 5'd13, 32'hFFFF_ABA7);
        @(negedge clk);
        hw_irq = 6'b0; exc_valid = 1'b1; exc_code = 5'd0;
        @(negedge clk);
        exc_valid = 1'b0;
        wr(5'd13, 32'h0);         rd_chk("R5 clear", 5'd13, 32'h0);
    endtask

    task automatic t_status();
        wr(5'd12, 32'hFFFF_FFFF);
        rd_chk("R6 stat ones", 5'd12, 32'hFFFF_FFFF);
        cmp("R6 no pend", {31'd0, irq_req}, 32'd0);
        cmp("R8 both", {30'd0, dspace_sel}, 32'd1);
        wr(5'd12, 32'h0001_0000); cmp("R8 iso", {30'd0, dspace_sel}, 32'd2);
        wr(5'd12, 32'h0002_0000); cmp("R8 swp", {30'd0, dspace_sel}, 32'd0);
        wr(5'd12, 32'h0003_0000); cmp("R8 both2", {30'd0, dspace_sel}, 32'd1);
        wr(5'd12, 32'h0);         cmp("R8 none", {30'd0, dspace_sel}, 32'd0);
    endtask

    task automatic t_swirq();
        wr(5'd12, 32'h0000_0101);
        wr(5'd13, 32'h0000_0100); cmp("R7 raise", {31'd0, irq_req}, 32'd1);
        wr(5'd13, 32'h0);         cmp("R7 clear", {31'd0, irq_req}, 32'd0);
        wr(5'd12, 32'h0000_0100);
        wr(5'd13, 32'h0000_0100); cmp("R7 en off", {31'd0, irq_req}, 32'd0);
        wr(5'd12, 32'h0000_0101); cmp("R6 en on", {31'd0, irq_req}, 32'd1);
        wr(5'd12, 32'h0000_0201); cmp("R6 masked", {31'd0, irq_req}, 32'd0);
        wr(5'd13, 32'h0000_0200); cmp("R7 bit9", {31'd0, irq_req}, 32'd1);
        wr(5'd13, 32'h0);
        wr(5'd12, 32'h0000_8001);
        @(negedge clk); hw_irq = 6'b100000;
        @(negedge clk); cmp("R6 hw line", {31'd0, irq_req}, 32'd1);
        hw_irq = 6'b000001;
        @(negedge clk); cmp("R6 hw masked", {31'd0, irq_req}, 32'd0);
        hw_irq = 6'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_cause();
        t_status();
        t_swirq();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule